// File: doc/BRIEF.md
# Interrupt Flag and Blanking Status Unit

This block keeps the two interrupt flags of a video-synchronised processor: the vertical-blank NMI flag and the timer IRQ flag. It also holds their enable bits and reports where the raster currently sits. External logic pulses `nmiRaise` when vertical blank begins and `irqRaise` when the timer comparator matches. The CPU reads the flags through a small register window, and each read clears the flag it returns. The block sends one-cycle transition pulses to the CPU core when an interrupt should be taken.

A status byte is built combinationally from the horizontal and vertical counters and the overscan mode. It reports vertical blank, horizontal blank, and a short busy window at the start of vertical blank, when controllers are polled automatically. Any read bit that the block does not define is taken from the `openBus` byte. Register select values are: 0 = control (write), 1 = NMI flag, 2 = IRQ flag, 3 = blanking status. Reads return `rdData` combinationally in the same cycle and show the state before any clear, which takes effect at the next clock edge. Transition pulses are registered and are high for the single cycle that follows the edge at which their cause was sampled.

Top module: `irq_flag_status`

## Requirements
- R1: After reset both flags and all enables are clear, `nmiEdge`, `irqEdge` and `autoPollEn` are 0, and flag reads show bit 7 as 0.
- R2: A read at select 1 returns {NMI flag, openBus[6:4], 4'h2}; the NMI flag is clear from the next edge onward.
- R3: A read at select 2 returns {IRQ flag, openBus[6:0]}; the IRQ flag is clear from the next edge onward.
- R4: When a read of a flag and the raise event for that flag fall in the same cycle, the flag is set after the edge.
- R5: Status bit 7 (select 3) is 1 when vCount >= 225 with `overscan`=0, and when vCount >= 240 with `overscan`=1; otherwise it is 0.
- R6: Status bit 6 is 1 exactly when hCount <= 2 or hCount >= 1096.
- R7: Status bit 0 is 1 exactly when vCount lies between the blank-start line of R5 and that line plus 2, inclusive; status bits 5:1 equal openBus[5:1].
- R8: A write at select 0 loads NMI enable from bit 7, vertical IRQ enable from bit 5, horizontal IRQ enable from bit 4 and auto-poll enable from bit 0; `autoPollEn` shows bit 0 after the edge.
- R9: A control write that takes NMI enable from 0 to 1 while the NMI flag is set pulses `nmiEdge` for one cycle. A write that leaves NMI enable at 1 does not pulse it.
- R10: `nmiRaise` always sets the NMI flag. It pulses `nmiEdge` only if the flag was clear and NMI is enabled.
- R11: A control write with bits 5 and 4 both 0 clears the IRQ flag and suppresses any `irqEdge` at that edge. While both IRQ enables are 0, `irqRaise` is ignored.
- R12: A control write with bit 5 = 1 and bit 4 = 0 while the IRQ flag is set pulses `irqEdge`. `irqRaise` with the flag clear and either IRQ enable set also pulses `irqEdge`.
- R13: A read at select 0 returns `openBus` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears the selected flag) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| openBus | input | 8 | Byte supplying undefined read bits |
| hCount | input | 11 | Horizontal counter |
| vCount | input | 9 | Vertical counter |
| overscan | input | 1 | Overscan mode (blank starts at line 240) |
| nmiRaise | input | 1 | Vertical-blank start event |
| irqRaise | input | 1 | Timer match event |
| nmiEdge | output | 1 | NMI transition pulse |
| irqEdge | output | 1 | IRQ transition pulse |
| autoPollEn | output | 1 | Auto controller-poll enable |

## Verification
The hardest situations to reach from the ports are the coincidences: a flag read or a control write landing at the same edge as a raise event, and an enable write arriving while a flag is already set. The stimulus first sets a flag with enables off. It then applies enable writes with chosen bit patterns, and next drives the raise input together with a read or a disabling write in one cycle. After each of these steps it reads the flags back to show what survived. The status byte and the control decode are swept across every line in both overscan modes, every horizontal position and every write value.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_IRQ  = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    ctrlWr;
    logic    nmiRd;
    logic    irqRd;
    regSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  output strobe_t    strobes
);
  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobes.ctrlWr = regWr && (sel == SEL_CTRL);
    strobes.nmiRd  = regRd && (sel == SEL_NMI);
    strobes.irqRd  = regRd && (sel == SEL_IRQ);
    strobes.rdSel  = sel;
  end
endmodule

// File: rtl/irq_flag_dpath.sv
module irq_flag_dpath
  import irq_flag_pkg::*;
#(
  parameter int H_W         = 11,
  parameter int V_W         = 9,
  parameter int VB_NORMAL   = 225,
  parameter int VB_OVERSCAN = 240,
  parameter int POLL_LINES  = 3,
  parameter int HB_END      = 2,
  parameter int HB_START    = 1096,
  parameter int REVISION    = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobes,
  input  logic [7:0]     wrData,
  input  logic [7:0]     openBus,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  input  logic           overscan,
  input  logic           nmiRaise,
  input  logic           irqRaise,
  output logic [7:0]     rdData,
  output logic           nmiEdge,
  output logic           irqEdge,
  output logic           autoPollEn,
  output logic           nmiLine,
  output logic           irqLine
);
  localparam logic [V_W-1:0] VB_N   = V_W'(VB_NORMAL);
  localparam logic [V_W-1:0] VB_O   = V_W'(VB_OVERSCAN);
  localparam logic [V_W-1:0] POLL_SPAN = V_W'(POLL_LINES - 1);
  localparam logic [H_W-1:0] HB_LO  = H_W'(HB_END);
  localparam logic [H_W-1:0] HB_HI  = H_W'(HB_START);
  localparam logic [3:0]     REV_NIB = 4'(REVISION);

  logic nmiEn, vIrqEn, hIrqEn;
  logic nmiEnNext, vIrqEnNext, hIrqEnNext, pollEnNext;
  logic irqAnyNext;
  logic nmiLineNext, irqLineNext, nmiEdgeNext, irqEdgeNext;

  logic unusedWr;
  assign unusedWr = ^{wrData[6], wrData[3:1]};

  always_comb begin
    nmiEnNext  = strobes.ctrlWr ? wrData[7] : nmiEn;
    vIrqEnNext = strobes.ctrlWr ? wrData[5] : vIrqEn;
    hIrqEnNext = strobes.ctrlWr ? wrData[4] : hIrqEn;
    pollEnNext = strobes.ctrlWr ? wrData[0] : autoPollEn;
    irqAnyNext = vIrqEnNext || hIrqEnNext;

    // NMI flag: raise beats read-clear
    if (nmiRaise)           nmiLineNext = 1'b1;
    else if (strobes.nmiRd) nmiLineNext = 1'b0;
    else                    nmiLineNext = nmiLine;
    nmiEdgeNext = (nmiRaise && !nmiLine && nmiEnNext)
               || (strobes.ctrlWr && !nmiEn && wrData[7] && nmiLine);

    // IRQ flag: full disable wins, then raise, then read-clear
    if (!irqAnyNext)                irqLineNext = strobes.ctrlWr ? 1'b0 : irqLine;
    else if (irqRaise)              irqLineNext = 1'b1;
    else if (strobes.irqRd)         irqLineNext = 1'b0;
    else                            irqLineNext = irqLine;
    if (!irqAnyNext && !strobes.ctrlWr && strobes.irqRd) irqLineNext = 1'b0;
    irqEdgeNext = irqAnyNext &&
                  ((irqRaise && !irqLine) ||
                   (strobes.ctrlWr && wrData[5] && !wrData[4] && irqLine));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiEn      <= 1'b0;
      vIrqEn     <= 1'b0;
      hIrqEn     <= 1'b0;
      autoPollEn <= 1'b0;
      nmiLine    <= 1'b0;
      irqLine    <= 1'b0;
      nmiEdge    <= 1'b0;
      irqEdge    <= 1'b0;
    end else begin
      nmiEn      <= nmiEnNext;
      vIrqEn     <= vIrqEnNext;
      hIrqEn     <= hIrqEnNext;
      autoPollEn <= pollEnNext;
      nmiLine    <= nmiLineNext;
      irqLine    <= irqLineNext;
      nmiEdge    <= nmiEdgeNext;
      irqEdge    <= irqEdgeNext;
    end
  end

  // Raster status
  logic [V_W-1:0] vbStart;
  logic inVblank, pollBusy, inHblank;
  assign vbStart  = overscan ? VB_O : VB_N;
  assign inVblank = vCount >= vbStart;
  assign pollBusy = inVblank && (vCount <= vbStart + POLL_SPAN);
  assign inHblank = (hCount <= HB_LO) || (hCount >= HB_HI);

  always_comb begin
    unique case (strobes.rdSel)
      SEL_NMI:  rdData = {nmiLine, openBus[6:4], REV_NIB};
      SEL_IRQ:  rdData = {irqLine, openBus[6:0]};
      SEL_STAT: rdData = {inVblank, inHblank, openBus[5:1], pollBusy};
      default:  rdData = openBus;
    endcase
  end
endmodule

// File: rtl/irq_flag_status.sv
module irq_flag_status
  import irq_flag_pkg::*;
#(
  parameter int H_W         = 11,
  parameter int V_W         = 9,
  parameter int VB_NORMAL   = 225,
  parameter int VB_OVERSCAN = 240,
  parameter int POLL_LINES  = 3,
  parameter int HB_END      = 2,
  parameter int HB_START    = 1096,
  parameter int REVISION    = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     regAddr,
  input  logic           regWr,
  input  logic           regRd,
  input  logic [7:0]     wrData,
  output logic [7:0]     rdData,
  input  logic [7:0]     openBus,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  input  logic           overscan,
  input  logic           nmiRaise,
  input  logic           irqRaise,
  output logic           nmiEdge,
  output logic           irqEdge,
  output logic           autoPollEn
);
  strobe_t strobes;
  logic nmiLine, irqLine;

  irq_flag_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .strobes (strobes)
  );

  irq_flag_dpath #(
    .H_W(H_W), .V_W(V_W), .VB_NORMAL(VB_NORMAL), .VB_OVERSCAN(VB_OVERSCAN),
    .POLL_LINES(POLL_LINES), .HB_END(HB_END), .HB_START(HB_START),
    .REVISION(REVISION)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .openBus    (openBus),
    .hCount     (hCount),
    .vCount     (vCount),
    .overscan   (overscan),
    .nmiRaise   (nmiRaise),
    .irqRaise   (irqRaise),
    .rdData     (rdData),
    .nmiEdge    (nmiEdge),
    .irqEdge    (irqEdge),
    .autoPollEn (autoPollEn),
    .nmiLine    (nmiLine),
    .irqLine    (irqLine)
  );
endmodule

// File: rtl/irq_flag_checker.sv
module irq_flag_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWr,
  input logic       regRd,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       nmiRaise,
  input logic       irqRaise,
  input logic       nmiEdge,
  input logic       irqEdge,
  input logic       autoPollEn,
  input logic       nmiLine,
  input logic       irqLine
);
  a_r2_nmi_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 2'd1 && !nmiRaise) |=> !nmiLine);

  a_r3_irq_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 2'd2 && !irqRaise) |=> !irqLine);

  a_r4_raise_wins: assert property (@(posedge clk) disable iff (!rstN)
    nmiRaise |=> nmiLine);

  a_r7_poll_inside_vblank: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> (!rdData[0] || rdData[7]));

  a_r8_poll_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0) |=> (autoPollEn == $past(wrData[0])));

  a_r9_nmi_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    nmiEdge |=> !nmiEdge);

  a_r11_irq_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && wrData[5:4] == 2'b00) |=> (!irqLine && !irqEdge));

  a_r12_vert_enable_edge: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && wrData[5:4] == 2'b10 && irqLine) |=> irqEdge);
endmodule

bind irq_flag_status irq_flag_checker u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .wrData(wrData), .rdData(rdData), .nmiRaise(nmiRaise), .irqRaise(irqRaise),
  .nmiEdge(nmiEdge), .irqEdge(irqEdge), .autoPollEn(autoPollEn),
  .nmiLine(nmiLine), .irqLine(irqLine)
);

// File: tb/sim_irq_flag_status.sv
`timescale 1ns/1ps
module sim_irq_flag_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic [7:0]  openBus = 8'hA5;
  logic [10:0] hCount = 11'd100;
  logic [8:0]  vCount = 9'd10;
  logic        overscan = 1'b0;
  logic        nmiRaise = 1'b0;
  logic        irqRaise = 1'b0;
  logic        nmiEdge, irqEdge, autoPollEn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_flag_status u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .openBus(openBus), .hCount(hCount),
    .vCount(vCount), .overscan(overscan), .nmiRaise(nmiRaise),
    .irqRaise(irqRaise), .nmiEdge(nmiEdge), .irqEdge(irqEdge),
    .autoPollEn(autoPollEn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    regWr = 1'b0; regRd = 1'b0; nmiRaise = 1'b0; irqRaise = 1'b0;
  endtask

  task automatic wrCtrl(input logic [7:0] d, input logic rn, input logic ri);
    regAddr = 2'd0; wrData = d; regWr = 1'b1; nmiRaise = rn; irqRaise = ri;
    cyc();
    clearIn();
  endtask

  task automatic rdReg(input logic [1:0] a, input logic rn, input logic ri,
                       output logic [7:0] v);
    regAddr = a; regRd = 1'b1; nmiRaise = rn; irqRaise = ri;
    #1 v = rdData;
    cyc();
    clearIn();
  endtask

  task automatic raise(input logic rn, input logic ri);
    nmiRaise = rn; irqRaise = ri;
    cyc();
    clearIn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    check("R1 nmiEdge", 16'(nmiEdge), 16'd0);
    check("R1 irqEdge", 16'(irqEdge), 16'd0);
    check("R1 autoPollEn", 16'(autoPollEn), 16'd0);
    openBus = 8'hA5;
    regAddr = 2'd1; #1 check("R1 nmi byte", 16'(rdData), 16'h22);
    regAddr = 2'd2; #1 check("R1 irq byte", 16'(rdData), 16'h25);

    // R13 control select reads back open bus
    for (int b = 0; b < 256; b += 17) begin
      openBus = 8'(b); regAddr = 2'd0;
      #1 check("R13 open bus", 16'(rdData), 16'(b));
    end
    openBus = 8'hA5;

    // R8 / R9: every control value, flags clear so no pulses
    for (int d = 0; d < 256; d++) begin
      wrCtrl(8'(d), 1'b0, 1'b0);
      check("R8 autoPollEn", 16'(autoPollEn), 16'(d & 1));
      check("R9 no nmiEdge with flag clear", 16'(nmiEdge), 16'd0);
      check("R12 no irqEdge with flag clear", 16'(irqEdge), 16'd0);
    end
    wrCtrl(8'h00, 1'b0, 1'b0);

    // R10 raise with NMI disabled: flag set, no pulse
    raise(1'b1, 1'b0);
    check("R10 no pulse disabled", 16'(nmiEdge), 16'd0);
    regAddr = 2'd1; #1 check("R10 flag set", 16'(rdData[7]), 16'd1);

    // R9 enable while flag high
    wrCtrl(8'h80, 1'b0, 1'b0);
    check("R9 enable pulse", 16'(nmiEdge), 16'd1);
    cyc();
    check("R9 pulse one cycle", 16'(nmiEdge), 16'd0);
    wrCtrl(8'h81, 1'b0, 1'b0);
    check("R9 re-enable no pulse", 16'(nmiEdge), 16'd0);

    // R2 read format and clear
    openBus = 8'h5A;
    rdReg(2'd1, 1'b0, 1'b0, v);
    check("R2 nmi byte", 16'(v), 16'(8'h80 | (8'h5A & 8'h70) | 8'h02));
    rdReg(2'd1, 1'b0, 1'b0, v);
    check("R2 cleared", 16'(v[7]), 16'd0);

    // R10 raise enabled with flag clear
    raise(1'b1, 1'b0);
    check("R10 pulse enabled", 16'(nmiEdge), 16'd1);

    // R4 read and raise together, flag already set
    rdReg(2'd1, 1'b1, 1'b0, v);
    check("R4 read shows set", 16'(v[7]), 16'd1);
    check("R4 no new pulse", 16'(nmiEdge), 16'd0);
    rdReg(2'd1, 1'b0, 1'b0, v);
    check("R4 flag kept", 16'(v[7]), 16'd1);
    // flag now clear; read and raise together
    rdReg(2'd1, 1'b1, 1'b0, v);
    check("R4 read shows old clear", 16'(v[7]), 16'd0);
    check("R4 pulse from raise", 16'(nmiEdge), 16'd1);
    regAddr = 2'd1; #1 check("R4 flag set after", 16'(rdData[7]), 16'd1);

    // R11 raise ignored with both IRQ enables clear
    wrCtrl(8'h00, 1'b0, 1'b0);
    raise(1'b0, 1'b1);
    check("R11 raise ignored edge", 16'(irqEdge), 16'd0);
    regAddr = 2'd2; #1 check("R11 raise ignored flag", 16'(rdData[7]), 16'd0);

    // R12 horizontal enable, raise
    wrCtrl(8'h10, 1'b0, 1'b0);
    raise(1'b0, 1'b1);
    check("R12 raise pulse", 16'(irqEdge), 16'd1);
    openBus = 8'h3C;
    rdReg(2'd2, 1'b0, 1'b0, v);
    check("R3 irq byte", 16'(v), 16'h80 | 16'h3C);
    rdReg(2'd2, 1'b0, 1'b0, v);
    check("R3 cleared", 16'(v[7]), 16'd0);

    // R4 irq: read with raise while flag set
    raise(1'b0, 1'b1);
    rdReg(2'd2, 1'b0, 1'b1, v);
    check("R4 irq no pulse", 16'(irqEdge), 16'd0);
    regAddr = 2'd2; #1 check("R4 irq kept", 16'(rdData[7]), 16'd1);

    // R12 vertical-only enable with flag high
    wrCtrl(8'h20, 1'b0, 1'b0);
    check("R12 vertical enable pulse", 16'(irqEdge), 16'd1);
    wrCtrl(8'h30, 1'b0, 1'b0);
    check("R12 both enables no pulse", 16'(irqEdge), 16'd0);

    // R11 full disable clears flag
    wrCtrl(8'h00, 1'b0, 1'b0);
    regAddr = 2'd2; #1 check("R11 disable clears", 16'(rdData[7]), 16'd0);
    wrCtrl(8'h10, 1'b0, 1'b0);
    wrCtrl(8'h00, 1'b0, 1'b1);
    check("R11 disable beats raise edge", 16'(irqEdge), 16'd0);
    regAddr = 2'd2; #1 check("R11 disable beats raise flag", 16'(rdData[7]), 16'd0);

    // R5 / R7 line sweep, both overscan modes
    openBus = 8'h5A; hCount = 11'd100; regAddr = 2'd3;
    for (int os = 0; os < 2; os++) begin
      for (int ln = 0; ln < 262; ln++) begin
        int vbs;
        logic [7:0] exp;
        vbs = (os != 0) ? 240 : 225;
        overscan = os[0]; vCount = 9'(ln);
        exp = {(ln >= vbs) ? 1'b1 : 1'b0, 1'b0, openBus[5:1],
               (ln >= vbs && ln <= vbs + 2) ? 1'b1 : 1'b0};
        #1 check("R5 R7 status line", 16'(rdData), 16'(exp));
      end
    end

    // R6 dot sweep
    overscan = 1'b0; vCount = 9'd10;
    for (int h = 0; h < 1364; h++) begin
      hCount = 11'(h);
      #1 check("R6 hblank", 16'(rdData[6]), 16'((h <= 2 || h >= 1096) ? 1 : 0));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule